// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-state controller of a small microcontroller-style system. Software selects a target low-power mode on a request input. The mode is taken only when the CPU issues a wait-for-interrupt or wait-for-event strobe, or when the CPU returns from an interrupt handler while automatic re-sleep is enabled. The block then drives the CPU clock gate, the peripheral clock enable, the regulator mode and the backup-register clear. Each state listens only to its own set of wake sources.

Light sleep keeps the peripherals clocked and returns to Run on the next edge. The three stop depths shut the peripheral clock, pick a regulator mode and, once woken, hold the CPU clock gated for a programmable latency count. After a stop the system clock select is forced to the internal oscillator. Leaving Standby or Shutdown is treated as a reset: a one-cycle warm-reset strobe is issued. A wake from Standby also sets a sticky flag that software clears.

Top module: `lpm_sequencer`

## Requirements
- R1: In Sleep the CPU clock enable is 0, the peripheral clock enable is 1 and the regulator code is 0. After a wait-for-interrupt entry, only `irq_pend_i` wakes the block, and it is in Run after the next clock edge. Request codes 0, 6 and 7 select Sleep.
- R2: After a wait-for-event entry into Sleep, `event_i` wakes the block. `irq_pend_i` wakes it only while `sev_on_pend_i` is 1.
- R3: With `sleep_on_exit_i` at 1, a `handler_ret_i` pulse in Run enters Sleep with wait-for-interrupt wake rules. With `sleep_on_exit_i` at 0 the pulse has no effect.
- R4: `mode_req_i` is sampled only at a `wfi_i`/`wfe_i` strobe. If a wake source of the requested Sleep or Stop state is already active at the strobe, the block stays in Run. A Standby or Shutdown entry is never cancelled this way.
- R5: After a Stop wake source is seen at clock edge k, the CPU clock enable stays 0 and rises after edge k+N+1. N is `lat_stop0_i`, `lat_stop1_i` or `lat_stop2_i` for request codes 1, 2 and 3. The peripheral clock enable stays 0 throughout.
- R6: Stop 2 (code 3) wakes only on `wkpin_i`, `lpuart_i` or `rtc_alarm_i`. Stop 0 and Stop 1 (codes 1, 2) also wake on `lptim_i` and `i2c_wake_i`.
- R7: `reg_mode_o` is 0 (main) in Run, Sleep, Stop 0 and during a wake count. It is 1 (low-power) in Stop 1, 2 (reduced low-power) in Stop 2, and 3 (off) in Standby and Shutdown.
- R8: `hs_clk_int_o` (1 = internal oscillator) follows `clk_sel_i` when `clk_sel_we_i` is 1. It is forced to 1 on every return from Stop, Standby or Shutdown. A return from Sleep leaves it unchanged.
- R9: Standby (code 4) wakes on a rising edge of `wkpin_i`, or on `rtc_alarm_i`, `rtc_wut_i`, `tamper_i` or `nrst_pin_i`. On wake the block returns to Run with `warm_rst_o` high for exactly one cycle and `standby_flag_o` set.
- R10: `standby_flag_o` stays at 1 until a `flag_clr_i` pulse clears it.
- R11: Shutdown (code 5) wakes only on a rising edge of `wkpin_i` or on `nrst_pin_i`. `bkp_clear_o` is 1 throughout Shutdown. On wake, `warm_rst_o` pulses and `standby_flag_o` is not set.
- R12: After reset the block is in Run with both clock enables at 1, regulator code 0 and `hs_clk_int_o` at 1. `warm_rst_o`, `standby_flag_o` and `bkp_clear_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req_i | input | 3 | Requested mode: 0 Sleep, 1 Stop 0, 2 Stop 1, 3 Stop 2, 4 Standby, 5 Shutdown |
| wfi_i | input | 1 | Wait-for-interrupt entry strobe |
| wfe_i | input | 1 | Wait-for-event entry strobe |
| sleep_on_exit_i | input | 1 | Re-enter Sleep on handler return |
| handler_ret_i | input | 1 | CPU interrupt-handler return pulse |
| sev_on_pend_i | input | 1 | Pending interrupt counts as event |
| irq_pend_i | input | 1 | Enabled interrupt pending |
| event_i | input | 1 | Event input |
| wkpin_i | input | 1 | Wake pin / external line |
| rtc_alarm_i | input | 1 | RTC alarm |
| rtc_wut_i | input | 1 | RTC periodic wake timer |
| tamper_i | input | 1 | Tamper / timestamp event |
| nrst_pin_i | input | 1 | Reset pin asserted |
| lpuart_i | input | 1 | Low-power UART wake |
| lptim_i | input | 1 | Low-power timer wake |
| i2c_wake_i | input | 1 | I2C address-match wake |
| lat_stop0_i | input | LAT_W | Stop 0 wake latency in cycles |
| lat_stop1_i | input | LAT_W | Stop 1 wake latency in cycles |
| lat_stop2_i | input | LAT_W | Stop 2 wake latency in cycles |
| clk_sel_we_i | input | 1 | Clock-select write strobe |
| clk_sel_i | input | 1 | Clock-select write value |
| flag_clr_i | input | 1 | Clear standby flag |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| hs_clk_int_o | output | 1 | 1 = internal high-speed oscillator selected |
| reg_mode_o | output | 2 | Regulator mode code |
| warm_rst_o | output | 1 | One-cycle warm reset strobe |
| standby_flag_o | output | 1 | Sticky woke-from-Standby flag |
| bkp_clear_o | output | 1 | Backup-register clear |

## Verification
The main sweep enters every request code, 0 to 7, through a wait-for-interrupt strobe and then raises each of ten wake sources alone. This separates the wake set of each state: Sleep, the two shallow stops, Stop 2, Standby and Shutdown each accept a different subset. Latency is measured in cycles for each stop depth, with different counts loaded into the three latency inputs, so a wrong mux choice or an off-by-one count shows up. Directed patterns cover the event-entry rules with and without send-on-pending, automatic re-sleep, cancellation by an already-active source, and a held wake pin that must not count as an edge. They also cover the sticky flag and the clock-select override.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam logic [2:0] MR_SLEEP = 3'd0;
    localparam logic [2:0] MR_STOP0 = 3'd1;
    localparam logic [2:0] MR_STOP1 = 3'd2;
    localparam logic [2:0] MR_STOP2 = 3'd3;
    localparam logic [2:0] MR_STBY  = 3'd4;
    localparam logic [2:0] MR_SHUT  = 3'd5;

    typedef enum logic [2:0] {
        ST_RUN, ST_SLEEP, ST_STOP, ST_WAKE, ST_STBY, ST_SHUT
    } state_t;

    typedef enum logic [1:0] {
        RG_MAIN = 2'd0, RG_LP = 2'd1, RG_LPR = 2'd2, RG_OFF = 2'd3
    } reg_t;

    // wake rule set attached to each low-power state
    typedef enum logic [2:0] {
        TG_SLP_WFI, TG_SLP_WFE, TG_STOP01, TG_STOP2, TG_STBY, TG_SHUT
    } tgt_t;

    typedef struct packed {
        logic irq;
        logic evt;
        logic pin;
        logic pin_rise;
        logic alarm;
        logic wut;
        logic tamper;
        logic nrst;
        logic lpuart;
        logic lptim;
        logic i2c;
    } wake_src_t;

    function automatic tgt_t req_target(logic [2:0] mode, logic by_event);
        case (mode)
            MR_STOP0, MR_STOP1: return TG_STOP01;
            MR_STOP2:           return TG_STOP2;
            MR_STBY:            return TG_STBY;
            MR_SHUT:            return TG_SHUT;
            default:            return by_event ? TG_SLP_WFE : TG_SLP_WFI;
        endcase
    endfunction

    function automatic logic is_light(tgt_t t);
        return (t == TG_SLP_WFI) || (t == TG_SLP_WFE) ||
               (t == TG_STOP01)  || (t == TG_STOP2);
    endfunction

    function automatic logic wake_hit(tgt_t t, wake_src_t s, logic sev);
        case (t)
            TG_SLP_WFI: return s.irq;
            TG_SLP_WFE: return s.evt | (sev & s.irq);
            TG_STOP01:  return s.pin | s.lpuart | s.alarm | s.lptim | s.i2c;
            TG_STOP2:   return s.pin | s.lpuart | s.alarm;
            TG_STBY:    return s.pin_rise | s.alarm | s.wut | s.tamper | s.nrst;
            default:    return s.pin_rise | s.nrst;
        endcase
    endfunction

endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel
    import lpm_pkg::*;
(
    input  tgt_t      tgt,
    input  wake_src_t src,
    input  logic      sev,
    output logic      hit
);
    always_comb hit = wake_hit(tgt, src, sev);
endmodule

// File: rtl/lpm_lat_cnt.sv
module lpm_lat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= val;
        else if (en && cnt != '0)  cnt <= cnt - ONE;
    end

    assign done = (cnt == '0);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R5
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_req_i,
    input  logic             wfi_i,
    input  logic             wfe_i,
    input  logic             sleep_on_exit_i,
    input  logic             handler_ret_i,
    input  logic             sev_on_pend_i,
    input  logic             irq_pend_i,
    input  logic             event_i,
    input  logic             wkpin_i,
    input  logic             rtc_alarm_i,
    input  logic             rtc_wut_i,
    input  logic             tamper_i,
    input  logic             nrst_pin_i,
    input  logic             lpuart_i,
    input  logic             lptim_i,
    input  logic             i2c_wake_i,
    input  logic [LAT_W-1:0] lat_stop0_i,
    input  logic [LAT_W-1:0] lat_stop1_i,
    input  logic [LAT_W-1:0] lat_stop2_i,
    input  logic             clk_sel_we_i,
    input  logic             clk_sel_i,
    input  logic             flag_clr_i,
    output logic             cpu_clk_en_o,
    output logic             periph_clk_en_o,
    output logic             hs_clk_int_o,
    output logic [1:0]       reg_mode_o,
    output logic             warm_rst_o,
    output logic             standby_flag_o,
    output logic             bkp_clear_o
);
    state_t     state;
    tgt_t       cur_tgt;
    logic [2:0] stop_var;
    logic       pin_q;
    logic       clk_int;
    logic       sb_flag;
    logic       warm;

    wake_src_t  src;
    tgt_t       rt, ent_tgt;
    logic       strobe, ent_hit, cur_hit, lat_load, lat_done;
    logic [LAT_W-1:0] lat_val;

    always_comb begin
        src.irq      = irq_pend_i;
        src.evt      = event_i;
        src.pin      = wkpin_i;
        src.pin_rise = wkpin_i & ~pin_q;
        src.alarm    = rtc_alarm_i;
        src.wut      = rtc_wut_i;
        src.tamper   = tamper_i;
        src.nrst     = nrst_pin_i;
        src.lpuart   = lpuart_i;
        src.lptim    = lptim_i;
        src.i2c      = i2c_wake_i;
        strobe  = wfi_i | wfe_i;
        rt      = req_target(mode_req_i, wfe_i & ~wfi_i);
        ent_tgt = strobe ? rt : TG_SLP_WFI;
    end

    lpm_wake_sel u_ent (.tgt(ent_tgt), .src(src), .sev(sev_on_pend_i), .hit(ent_hit));
    lpm_wake_sel u_cur (.tgt(cur_tgt), .src(src), .sev(sev_on_pend_i), .hit(cur_hit));

    always_comb begin
        case (stop_var)
            MR_STOP0: lat_val = lat_stop0_i;
            MR_STOP1: lat_val = lat_stop1_i;
            default:  lat_val = lat_stop2_i;
        endcase
        lat_load = (state == ST_STOP) && cur_hit;
    end

    lpm_lat_cnt #(.W(LAT_W)) u_lat (
        .clk(clk), .rst(rst), .en(state == ST_WAKE), .load(lat_load),
        .val(lat_val), .done(lat_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            cur_tgt  <= TG_SLP_WFI;
            stop_var <= MR_SLEEP;
            pin_q    <= 1'b0;
            clk_int  <= 1'b1;
            sb_flag  <= 1'b0;
            warm     <= 1'b0;
        end else begin
            pin_q <= wkpin_i;
            warm  <= 1'b0;
            if (clk_sel_we_i) clk_int <= clk_sel_i;
            if (flag_clr_i)   sb_flag <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (strobe) begin
                        if (!(is_light(rt) && ent_hit)) begin
                            cur_tgt  <= rt;
                            stop_var <= mode_req_i;
                            case (rt)
                                TG_STOP01, TG_STOP2: state <= ST_STOP;
                                TG_STBY:             state <= ST_STBY;
                                TG_SHUT:             state <= ST_SHUT;
                                default:             state <= ST_SLEEP;
                            endcase
                        end
                    end else if (sleep_on_exit_i && handler_ret_i && !ent_hit) begin
                        cur_tgt <= TG_SLP_WFI;
                        state   <= ST_SLEEP;
                    end
                end
                ST_SLEEP: if (cur_hit) state <= ST_RUN;
                ST_STOP:  if (cur_hit) state <= ST_WAKE;
                ST_WAKE: if (lat_done) begin
                    state   <= ST_RUN;
                    clk_int <= 1'b1;
                end
                ST_STBY: if (cur_hit) begin
                    state   <= ST_RUN;
                    warm    <= 1'b1;
                    sb_flag <= 1'b1;
                    clk_int <= 1'b1;
                end
                default: if (cur_hit) begin
                    state   <= ST_RUN;
                    warm    <= 1'b1;
                    clk_int <= 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        cpu_clk_en_o    = (state == ST_RUN);
        periph_clk_en_o = (state == ST_RUN) || (state == ST_SLEEP);
        hs_clk_int_o    = clk_int;
        warm_rst_o      = warm;
        standby_flag_o  = sb_flag;
        bkp_clear_o     = (state == ST_SHUT);
        case (state)
            ST_STOP: case (stop_var)
                MR_STOP0: reg_mode_o = RG_MAIN;
                MR_STOP1: reg_mode_o = RG_LP;
                default:  reg_mode_o = RG_LPR;
            endcase
            ST_STBY, ST_SHUT: reg_mode_o = RG_OFF;
            default:          reg_mode_o = RG_MAIN;
        endcase
    end

    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && !lat_done) |=> (state == ST_WAKE && !cpu_clk_en_o)); // R5
    AST_STOP_CLK_INT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && lat_done) |=> (hs_clk_int_o && cpu_clk_en_o)); // R8
    AST_ENTRY_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && strobe && is_light(rt) && ent_hit) |=> cpu_clk_en_o); // R4
    AST_FLAG_WITH_RST: assert property (@(posedge clk) disable iff (rst)
        $rose(standby_flag_o) |-> warm_rst_o); // R9
    AST_WARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        warm_rst_o |=> !warm_rst_o); // R9
    AST_SHUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHUT && !cur_hit) |=> bkp_clear_o); // R11
endmodule

// File: tb/sim_lpm_sequencer.sv
module sim_lpm_sequencer;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, wfi, wfe, soe, hret, sev, irq, evt, pin, alarm, wut, tamper, nrst;
    logic lpuart, lptim, i2c, csel_we, csel, fclr;
    logic [2:0] mode;
    logic [7:0] lat0, lat1, lat2;
    logic cpu_en, per_en, clk_int, warm, sbf, bkp;
    logic [1:0] rmode;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    lpm_sequencer #(.LAT_W(8)) u0 (
        .clk(clk), .rst(rst), .mode_req_i(mode), .wfi_i(wfi), .wfe_i(wfe),
        .sleep_on_exit_i(soe), .handler_ret_i(hret), .sev_on_pend_i(sev),
        .irq_pend_i(irq), .event_i(evt), .wkpin_i(pin), .rtc_alarm_i(alarm),
        .rtc_wut_i(wut), .tamper_i(tamper), .nrst_pin_i(nrst), .lpuart_i(lpuart),
        .lptim_i(lptim), .i2c_wake_i(i2c), .lat_stop0_i(lat0), .lat_stop1_i(lat1),
        .lat_stop2_i(lat2), .clk_sel_we_i(csel_we), .clk_sel_i(csel),
        .flag_clr_i(fclr), .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en),
        .hs_clk_int_o(clk_int), .reg_mode_o(rmode), .warm_rst_o(warm),
        .standby_flag_o(sbf), .bkp_clear_o(bkp)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_src();
        irq = 0; evt = 0; pin = 0; alarm = 0; wut = 0; tamper = 0;
        nrst = 0; lpuart = 0; lptim = 0; i2c = 0;
    endtask

    task automatic do_reset();
        rst = 1; wfi = 0; wfe = 0; soe = 0; hret = 0; sev = 0; mode = 0;
        csel_we = 0; csel = 0; fclr = 0; lat0 = 2; lat1 = 3; lat2 = 4;
        clear_src();
        tick(); tick();
        rst = 0;
    endtask

    task automatic set_src(int s);
        case (s)
            0: irq = 1;    1: evt = 1;    2: pin = 1;    3: alarm = 1;
            4: wut = 1;    5: tamper = 1; 6: nrst = 1;   7: lpuart = 1;
            8: lptim = 1;  default: i2c = 1;
        endcase
    endtask

    function automatic bit exp_wake(int m, int s);
        case (m)
            1, 2:    return s == 2 || s == 3 || s == 7 || s == 8 || s == 9;
            3:       return s == 2 || s == 3 || s == 7;
            4:       return s == 2 || s == 3 || s == 4 || s == 5 || s == 6;
            5:       return s == 2 || s == 6;
            default: return s == 0;
        endcase
    endfunction

    // {cpu, periph, reg[1:0], bkp}
    function automatic int exp_entry(int m);
        case (m)
            1: return 5'b00_00_0;
            2: return 5'b00_01_0;
            3: return 5'b00_10_0;
            4: return 5'b00_11_0;
            5: return 5'b00_11_1;
            default: return 5'b01_00_0;
        endcase
    endfunction

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        do_reset();
        check({cpu_en, per_en, rmode, clk_int, warm, sbf, bkp}, 8'b11_00_1_000, "R12");

        // R1 R6 R7 R9 R11 sweep over request codes and wake sources
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 10; s++) begin
                do_reset();
                mode = m[2:0]; wfi = 1; tick(); wfi = 0;
                check({cpu_en, per_en, rmode, bkp}, exp_entry(m), "R7 entry");
                set_src(s);
                repeat (8) tick();
                check({cpu_en, sbf}, {exp_wake(m, s), (m == 4) && exp_wake(m, s)},
                      m < 4 || m > 5 ? "R1/R6 wake set" : (m == 4 ? "R9 wake set" : "R11 wake set"));
                clear_src();
            end
        end

        // R2 event entry
        do_reset();
        wfe = 1; tick(); wfe = 0;
        irq = 1; tick(); tick();
        check(cpu_en, 0, "R2 irq without sev");
        sev = 1; tick();
        check(cpu_en, 1, "R2 irq with sev");
        do_reset();
        wfe = 1; tick(); wfe = 0;
        evt = 1; tick();
        check(cpu_en, 1, "R2 event wake");

        // R3 sleep on exit
        do_reset();
        soe = 1; hret = 1; tick(); hret = 0;
        check({cpu_en, per_en}, 2'b01, "R3 re-sleep");
        irq = 1; tick(); irq = 0;
        check(cpu_en, 1, "R3 wake");
        soe = 0; hret = 1; tick(); hret = 0; tick();
        check(cpu_en, 1, "R3 disabled no effect");

        // R4 sampling and cancel
        do_reset();
        mode = 3; tick(); tick();
        check({cpu_en, rmode}, 3'b1_00, "R4 no strobe");
        irq = 1; mode = 0; wfi = 1; tick(); wfi = 0;
        check(cpu_en, 1, "R4 sleep cancel");
        irq = 0; pin = 1; mode = 3; wfi = 1; tick(); wfi = 0;
        check({cpu_en, rmode}, 3'b1_00, "R4 stop cancel");
        mode = 4; wfi = 1; tick(); wfi = 0;
        check(rmode, 3, "R4 standby not cancelled");
        tick(); tick();
        check(rmode, 3, "R9 held pin no edge");
        pin = 0; tick(); pin = 1; tick();
        check({cpu_en, warm, sbf, clk_int}, 4'b1111, "R9 wake strobe");
        tick();
        check({warm, sbf}, 2'b01, "R9 pulse width / R10 sticky");
        pin = 0; mode = 0; wfi = 1; tick(); wfi = 0;
        irq = 1; tick(); irq = 0; tick();
        check(sbf, 1, "R10 survives sleep");
        fclr = 1; tick(); fclr = 0;
        check(sbf, 0, "R10 clear");

        // R5 latency per variant
        for (int v = 1; v < 4; v++) begin
            for (int k = 0; k < 3; k++) begin
                int base = k * 3;
                int exp_lat;
                int cnt;
                bit per_seen;
                do_reset();
                lat0 = 8'(base); lat1 = 8'(base + 1); lat2 = 8'(base + 2);
                exp_lat = base + (v - 1) + 2;
                mode = v[2:0]; wfi = 1; tick(); wfi = 0;
                lpuart = 1;
                cnt = 0; per_seen = 0;
                do begin
                    tick(); cnt++;
                    if (!cpu_en && per_en) per_seen = 1;
                end while (!cpu_en && cnt < 40);
                check(cnt, exp_lat, "R5 latency");
                check(per_seen, 0, "R5 periph off");
                lpuart = 0;
            end
        end

        // R8 clock select
        do_reset();
        csel_we = 1; csel = 0; tick(); csel_we = 0;
        check(clk_int, 0, "R8 software write");
        wfi = 1; mode = 0; tick(); wfi = 0; irq = 1; tick(); irq = 0;
        check({cpu_en, clk_int}, 2'b10, "R8 sleep leaves select");
        mode = 1; wfi = 1; tick(); wfi = 0; alarm = 1; repeat (6) tick(); alarm = 0;
        check({cpu_en, clk_int}, 2'b11, "R8 stop forces internal");

        // R11 shutdown wake strobe without flag
        do_reset();
        mode = 5; wfi = 1; tick(); wfi = 0;
        wut = 1; tick(); tick();
        check(bkp, 1, "R11 ignores timer");
        wut = 0; nrst = 1; tick(); nrst = 0;
        check({cpu_en, warm, sbf, bkp}, 4'b1100, "R11 wake");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule